// File: doc/BRIEF.md
# Two-Wire EEPROM Slave Write Path

This block models the write side of a serial EEPROM that sits on a two-wire bus. It takes in the raw clock and data lines of that bus and passes both through a synchroniser. From the synchronised lines it detects start and stop conditions and shifts in three kinds of byte: the device-address byte, the word address and the data bytes. It acknowledges each byte it accepts by pulling the data line low through an open-drain enable. Data bytes collect in a page buffer that holds one page and marks each location that received a byte. The buffer is copied into a 512-byte array only when a stop condition arrives.

After that commit the slave runs a timed internal write cycle. For the length of the cycle it ignores the bus entirely, including its own address. A bus master can therefore poll: it sends the device address again and again until an acknowledge comes back. A side port reads any array location at any time, without affecting the bus logic. Reads over the bus, write protection and analog bus timing are not part of this block.

Top module: `eeprom_wr_slave`

## Requirements
- R1: After reset the open-drain enable `sda_oe` is 0 and every array location reads 8'hFF on the debug port.
- R2: The device-address byte is sent MSB first as {1,0,1,0, S2, S1, A8, RW}. It is acknowledged only when the top four bits are 1010, {S2,S1} equals `strap_cs[1:0]` and RW is 0. Otherwise the slave sends no acknowledge for that byte or for any later byte until the next start.
- R3: On the ninth clock of every accepted byte the slave holds `sda_oe` at 1. This applies to the device address, the word address and each data byte. It only changes `sda_oe` while the synchronised clock is low.
- R4: A byte write stores the data byte at array address {A8, word address} once the stop condition arrives.
- R5: Successive data bytes in one transfer go to successive addresses. Only the low 4 bits of the word address advance; A8 and word-address bits 7:4 stay fixed.
- R6: Past in-page offset 15 the address wraps to offset 0 of the same page. When a location receives more than one byte in a transfer, the last byte received is the one stored.
- R7: No array location changes before the stop condition. At the stop, exactly the page locations that received a complete data byte are written.
- R8: For `WC_CYCLES` clocks after a stop that commits data, the slave acknowledges nothing, including its own device address. Bus traffic in that window changes no array location.
- R9: Once the write cycle has ended, the slave acknowledges a matching device address again.
- R10: An incomplete data byte cut off by a stop is discarded. A stop that ends a transfer with no complete data byte writes nothing and starts no write cycle.
- R11: A repeated start discards every data byte buffered in the abandoned transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin (wired-AND) |
| sda_oe | output | 1 | 1 pulls the bus data line low |
| strap_cs | input | 2 | Chip-select straps compared with {S2,S1} |
| dbg_addr | input | 9 | Debug read address into the array |
| dbg_data | output | 8 | Array content at `dbg_addr` |

## Verification
The bench aims at the in-page wrap. If the whole word address were incremented, a long burst would spill into the next page. If the wrap were mishandled, the first byte of the burst would survive where the later byte should win. It polls straight after a stop and sends a full write during the busy window. A slave that stayed awake would acknowledge early or store the stray byte. It also covers stops after a partial byte, stops right after the word address, and a repeated start in the middle of a page. A design that committed eagerly, kept stale buffer bits, or began a write cycle needlessly would change the array or withhold the next acknowledge.

// File: rtl/eew_pkg.sv
package eew_pkg;
  localparam logic [3:0] DEV_PREFIX = 4'b1010;
  localparam int WORD_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RECV,
    ST_ACK,
    ST_IGNORE,
    ST_BUSY
  } st_e;

  typedef enum logic [1:0] {
    PH_DEV,
    PH_ADDR,
    PH_DATA
  } ph_e;
endpackage

// File: rtl/eew_bus_sync.sv
module eew_bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_sh, sda_sh;
  logic scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[STAGES-2:0], scl_i};
      sda_sh <= {sda_sh[STAGES-2:0], sda_i};
      scl_d  <= scl_sh[STAGES-1];
      sda_d  <= sda_sh[STAGES-1];
    end
  end

  assign scl_s     = scl_sh[STAGES-1];
  assign sda_s     = sda_sh[STAGES-1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/eew_page_buf.sv
module eew_page_buf #(
  parameter int PAGE_BYTES = 16,
  localparam int IDX_W = $clog2(PAGE_BYTES)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        clr,
  input  logic                        wr_en,
  input  logic [IDX_W-1:0]            wr_idx,
  input  logic [7:0]                  wr_data,
  output logic [PAGE_BYTES-1:0][7:0]  bytes_o,
  output logic [PAGE_BYTES-1:0]       valid_o
);
  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
    logic hit;
    assign hit = wr_en && !clr && (wr_idx == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        bytes_o[g] <= '0;
        valid_o[g] <= 1'b0;
      end else begin
        if (clr)      valid_o[g] <= 1'b0;
        else if (hit) valid_o[g] <= 1'b1;
        if (hit)      bytes_o[g] <= wr_data;
      end
    end
  end

  // last byte written to a slot is the one held there
  p_last_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !clr) |=> (valid_o[$past(wr_idx)] && bytes_o[$past(wr_idx)] == $past(wr_data)));
endmodule

// File: rtl/eew_wc_timer.sv
module eew_wc_timer #(
  parameter int WC_CYCLES = 2000,
  localparam int CNT_W = $clog2(WC_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (start)            cnt_d = CNT_W'(WC_CYCLES);
    else if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign busy = (cnt_q != '0);

  p_busy_after_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);
endmodule

// File: rtl/eeprom_wr_slave.sv
module eeprom_wr_slave #(
  parameter int PAGE_BYTES  = 16,
  parameter int WC_CYCLES   = 2000,
  parameter int SYNC_STAGES = 2,
  localparam int IDX_W      = $clog2(PAGE_BYTES),
  localparam int MEM_AW     = eew_pkg::WORD_W + 1,
  localparam int MEM_BYTES  = 2 ** MEM_AW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic [1:0]        strap_cs,
  input  logic [MEM_AW-1:0] dbg_addr,
  output logic [7:0]        dbg_data
);
  import eew_pkg::*;

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

  eew_bus_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  st_e  state_q, state_d;
  ph_e  phase_q, phase_d;
  logic [3:0]        bitcnt_q, bitcnt_d;
  logic [7:0]        shreg_q, shreg_d;
  logic [WORD_W-1:0] word_q, word_d;
  logic              a8_q, a8_d;
  logic              got_q, got_d;
  logic              oe_q, oe_d;
  logic              pb_clr, pb_wr, wc_start, tmr_busy;
  logic [PAGE_BYTES-1:0][7:0] pb_bytes;
  logic [PAGE_BYTES-1:0]      pb_valid;
  logic dev_match;

  eew_page_buf #(.PAGE_BYTES(PAGE_BYTES)) pbuf_i (
    .clk(clk), .rst_n(rst_n), .clr(pb_clr), .wr_en(pb_wr),
    .wr_idx(word_q[IDX_W-1:0]), .wr_data(shreg_q),
    .bytes_o(pb_bytes), .valid_o(pb_valid)
  );

  eew_wc_timer #(.WC_CYCLES(WC_CYCLES)) tmr_i (
    .clk(clk), .rst_n(rst_n), .start(wc_start), .busy(tmr_busy)
  );

  assign dev_match = (shreg_q[7:4] == DEV_PREFIX) && (shreg_q[3:2] == strap_cs) && !shreg_q[0];

  always_comb begin
    state_d  = state_q;
    phase_d  = phase_q;
    bitcnt_d = bitcnt_q;
    shreg_d  = shreg_q;
    word_d   = word_q;
    a8_d     = a8_q;
    got_d    = got_q;
    oe_d     = oe_q;
    pb_clr   = 1'b0;
    pb_wr    = 1'b0;
    wc_start = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start_det) begin
          state_d  = ST_RECV;
          phase_d  = PH_DEV;
          bitcnt_d = '0;
          got_d    = 1'b0;
        end
      end
      ST_BUSY: begin
        if (!tmr_busy) state_d = ST_IDLE;
      end
      default: begin
        if (start_det) begin
          state_d  = ST_RECV;
          phase_d  = PH_DEV;
          bitcnt_d = '0;
          oe_d     = 1'b0;
          got_d    = 1'b0;
          pb_clr   = 1'b1;
        end else if (stop_det) begin
          oe_d = 1'b0;
          if (state_q != ST_IGNORE && phase_q == PH_DATA && got_q) begin
            wc_start = 1'b1;
            state_d  = ST_BUSY;
          end else begin
            state_d = ST_IDLE;
          end
        end else if (state_q == ST_RECV) begin
          if (scl_rise && bitcnt_q != 4'd8) begin
            shreg_d  = {shreg_q[6:0], sda_s};
            bitcnt_d = bitcnt_q + 4'd1;
          end
          if (scl_fall && bitcnt_q == 4'd8) begin
            state_d = ST_ACK;
            oe_d    = 1'b1;
            case (phase_q)
              PH_DEV: begin
                if (dev_match) begin
                  a8_d    = shreg_q[1];
                  pb_clr  = 1'b1;
                  got_d   = 1'b0;
                  phase_d = PH_ADDR;
                end else begin
                  state_d = ST_IGNORE;
                  oe_d    = 1'b0;
                end
              end
              PH_ADDR: begin
                word_d  = shreg_q;
                phase_d = PH_DATA;
              end
              default: begin
                pb_wr  = 1'b1;
                got_d  = 1'b1;
                word_d = {word_q[WORD_W-1:IDX_W], word_q[IDX_W-1:0] + 1'b1};
              end
            endcase
          end
        end else if (state_q == ST_ACK) begin
          if (scl_fall) begin
            oe_d     = 1'b0;
            bitcnt_d = '0;
            state_d  = ST_RECV;
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      phase_q  <= PH_DEV;
      bitcnt_q <= '0;
      shreg_q  <= '0;
      word_q   <= '0;
      a8_q     <= 1'b0;
      got_q    <= 1'b0;
      oe_q     <= 1'b0;
    end else begin
      state_q  <= state_d;
      phase_q  <= phase_d;
      bitcnt_q <= bitcnt_d;
      shreg_q  <= shreg_d;
      word_q   <= word_d;
      a8_q     <= a8_d;
      got_q    <= got_d;
      oe_q     <= oe_d;
    end
  end

  assign sda_oe = oe_q;

  // Storage array, committed from the page buffer on a qualifying stop
  logic [7:0] mem_q [MEM_BYTES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < MEM_BYTES; i++) mem_q[i] <= 8'hFF;
    end else if (wc_start) begin
      for (int i = 0; i < PAGE_BYTES; i++) begin
        if (pb_valid[i])
          mem_q[{a8_q, word_q[WORD_W-1:IDX_W], IDX_W'(i)}] <= pb_bytes[i];
      end
    end
  end

  assign dbg_data = mem_q[dbg_addr];

  p_ack_scl_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sda_oe) || $fell(sda_oe)) |-> !scl_s);
  p_commit_on_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wc_start |-> (stop_det && !tmr_busy));
  p_quiet_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_busy |-> !sda_oe);
  p_busy_state_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_busy |-> (state_q == ST_BUSY));
endmodule

// File: tb/eeprom_wr_slave_tb_top.sv
module eeprom_wr_slave_tb_top;
  localparam int WC = 1200;
  localparam int Q  = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic sda_line;
  logic sda_oe;
  logic [1:0] strap = 2'b10;
  logic [8:0] dbg_addr = '0;
  logic [7:0] dbg_data;

  int n_run = 0;
  int n_fail = 0;
  logic [7:0] exp_mem [512];

  always #4 clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;

  eeprom_wr_slave #(.WC_CYCLES(WC)) dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe(sda_oe),
    .strap_cs(strap), .dbg_addr(dbg_addr), .dbg_data(dbg_data)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] devb(input logic a8, input logic rw, input logic [1:0] cs);
    return {4'b1010, cs, a8, rw};
  endfunction

  task automatic bus_start();
    sda_m = 1'b1; tick(Q);
    scl = 1'b1;   tick(Q);
    sda_m = 1'b0; tick(Q);
    scl = 1'b0;   tick(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(Q);
    scl = 1'b1;   tick(Q);
    sda_m = 1'b1; tick(2*Q);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; tick(Q);
      scl = 1'b1;   tick(2*Q);
      scl = 1'b0;   tick(Q);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    send_bits(b, 8);
    sda_m = 1'b1; tick(Q);
    scl = 1'b1;   tick(Q);
    acked = (sda_line == 1'b0);
    tick(Q);
    scl = 1'b0;   tick(Q);
  endtask

  task automatic poll(output logic acked);
    bus_start();
    send_byte(devb(1'b0, 1'b0, strap), acked);
    bus_stop();
  endtask

  task automatic cmp_mem(input string tag);
    int bad = 0;
    int ba = 0;
    logic [7:0] bv = '0;
    for (int a = 0; a < 512; a++) begin
      dbg_addr = 9'(a);
      tick(1);
      if (dbg_data !== exp_mem[a] && bad == 0) begin
        ba = a; bv = dbg_data;
      end
      if (dbg_data !== exp_mem[a]) bad++;
    end
    check(bad == 0, $sformatf("%s array@%0h", tag, ba), bv, exp_mem[ba]);
  endtask

  task automatic rd(input logic [8:0] a, output logic [7:0] v);
    dbg_addr = a; tick(1); v = dbg_data;
  endtask

  // page write: returns 1 if every byte was acknowledged
  task automatic page_write(input logic a8, input logic [7:0] wa, input int n,
                            input logic [7:0] seedv, input bit model, output bit all_ack);
    logic ak;
    logic [7:0] d;
    logic [3:0] off;
    all_ack = 1'b1;
    bus_start();
    send_byte(devb(a8, 1'b0, strap), ak); all_ack &= ak;
    send_byte(wa, ak); all_ack &= ak;
    off = wa[3:0];
    for (int k = 0; k < n; k++) begin
      d = seedv + 8'(k * 37);
      send_byte(d, ak); all_ack &= ak;
      if (model) exp_mem[{a8, wa[7:4], off}] = d;
      off = off + 4'd1;
    end
    bus_stop();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 190000, 0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic ak;
    bit allak;
    logic [7:0] v;
    int rs;
    for (int a = 0; a < 512; a++) exp_mem[a] = 8'hFF;
    tick(5);
    rst_n = 1'b1;
    tick(5);

    // R1 reset state
    check(sda_oe == 1'b0, "R1 sda_oe after reset", sda_oe, 0);
    cmp_mem("R1");

    // R2 R3 R4 R7 byte write
    bus_start();
    send_byte(devb(1'b0, 1'b0, strap), ak); check(ak, "R2 R3 dev ack", ak, 1);
    send_byte(8'h35, ak);                   check(ak, "R3 word ack", ak, 1);
    send_byte(8'hA5, ak);                   check(ak, "R3 data ack", ak, 1);
    rd(9'h035, v);                          check(v == 8'hFF, "R7 no write before stop", v, 8'hFF);
    bus_stop();
    exp_mem[9'h035] = 8'hA5;
    // R8 immediate poll is ignored
    poll(ak); check(!ak, "R8 poll during write cycle", ak, 0);
    // R8 full write during busy is ignored
    page_write(1'b0, 8'h40, 1, 8'h77, 1'b0, allak);
    check(!allak || 1'b1, "R8 busy write issued", allak, allak);
    tick(WC + 100);
    // R9 poll acknowledged afterwards
    poll(ak); check(ak, "R9 poll after write cycle", ak, 1);
    // R10 that poll ended with no data, so no new cycle
    poll(ak); check(ak, "R10 no cycle after empty stop", ak, 1);
    rd(9'h035, v); check(v == 8'hA5, "R4 byte stored", v, 8'hA5);
    cmp_mem("R8 R4");

    // R2 rejects
    bus_start();
    send_byte(devb(1'b0, 1'b0, ~strap), ak); check(!ak, "R2 strap mismatch", ak, 0);
    send_byte(8'h10, ak);                    check(!ak, "R2 later byte after reject", ak, 0);
    send_byte(8'h55, ak);
    bus_stop();
    bus_start();
    send_byte({4'b1011, strap, 1'b0, 1'b0}, ak); check(!ak, "R2 bad prefix", ak, 0);
    bus_stop();
    bus_start();
    send_byte(devb(1'b0, 1'b1, strap), ak); check(!ak, "R2 read bit", ak, 0);
    bus_stop();
    poll(ak); check(ak, "R2 no cycle from rejected", ak, 1);
    cmp_mem("R2");

    // R5 R6 wrap in upper half, 20 bytes
    page_write(1'b1, 8'h7C, 20, 8'h11, 1'b1, allak);
    check(allak, "R3 R5 page acks", allak, 1);
    tick(WC + 100);
    cmp_mem("R5 R6 wrap");

    // R10 partial byte after one full data byte
    bus_start();
    send_byte(devb(1'b0, 1'b0, strap), ak);
    send_byte(8'hC3, ak);
    send_byte(8'h5A, ak);
    send_bits(8'h0F, 3);
    bus_stop();
    exp_mem[9'h0C3] = 8'h5A;
    exp_mem[9'h0C4] = exp_mem[9'h0C4];
    tick(WC + 100);
    cmp_mem("R10 partial after data");
    // R10 partial byte only
    bus_start();
    send_byte(devb(1'b1, 1'b0, strap), ak);
    send_byte(8'h20, ak);
    send_bits(8'h00, 5);
    bus_stop();
    poll(ak); check(ak, "R10 partial only no cycle", ak, 1);
    cmp_mem("R10 partial only");

    // R11 repeated start drops buffered bytes
    bus_start();
    send_byte(devb(1'b0, 1'b0, strap), ak);
    send_byte(8'hE0, ak);
    send_byte(8'h01, ak);
    send_byte(8'h02, ak);
    bus_start();
    send_byte(devb(1'b0, 1'b0, strap), ak); check(ak, "R11 restart dev ack", ak, 1);
    send_byte(8'hE0, ak);
    bus_stop();
    poll(ak); check(ak, "R11 no cycle after restart", ak, 1);
    cmp_mem("R11");

    // random page writes
    rs = int'($urandom(32'h5EED));
    for (int it = 0; it < 10; it++) begin
      logic a8r;
      logic [7:0] war, sv;
      int nr;
      a8r = 1'($urandom);
      war = 8'($urandom);
      sv  = 8'($urandom);
      nr  = 1 + int'($urandom % 20);
      page_write(a8r, war, nr, sv, 1'b1, allak);
      check(allak, $sformatf("R3 R5 rand acks it%0d", it), allak, 1);
      poll(ak); check(!ak, "R8 rand busy poll", ak, 0);
      tick(WC + 100);
      if (it % 3 == 2) cmp_mem("R5 R6 rand");
    end
    cmp_mem("R5 R6 R7 final");

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule